// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block takes eight interrupt request lines, records each rising edge in a request register, filters the recorded requests through a mask, and raises a single interrupt line when the best pending request outranks everything already being serviced. Software reaches it through two byte addresses: address 0 carries commands, address 1 carries configuration bytes and the mask. After a start command, a short sequence of configuration bytes sets the vector base, the cascade wiring and the end-of-service policy. Once that sequence ends, the same addresses accept end-of-service commands, readback selection and mask updates.

An acknowledge strobe makes the controller resolve the winning input and return an interrupt vector one cycle later. It also marks that input as in service until software retires it. Two copies can be chained. The master reports, through a three-bit identity bus, which of its inputs carries a subordinate controller. The subordinate controller whose programmed identity matches that bus returns the vector in place of the master. A request line that drops before the acknowledge yields the lowest-priority vector without marking anything in service.

Top module: `cascade_pic`

## Requirements
- R1: After reset, int_out is low, vec_vld is low, a read at address 1 returns 0xFF (all inputs masked), and a read at address 0 returns 0x00.
- R2: A command-port write with bit 4 set starts configuration and clears the mask to 0x00. The next data-port writes are taken in this order: the vector base; then the cascade byte, which is skipped when bit 1 of the start command is set; then the mode byte, which is expected only when bit 0 of the start command is set. After the sequence, each data-port write loads the mask (bit n = 1 masks input n).
- R3: A rising edge on irq_in[n] latches request bit n. int_out goes high two cycles later if bit n is unmasked, the line is still high, and n is lower than every in-service bit. A masked input never raises int_out.
- R4: Input 0 has the highest priority. When ack is sampled, the lowest-index eligible request wins. In the cycle after ack, vec_vld is high and vec_out = {base[7:3], winning index}.
- R5: A non-cascade acknowledge clears the winner's request bit and, unless auto end-of-service is enabled, sets its in-service bit.
- R6: A command with bits[7:5] = 001 (0x20) clears the lowest-index set in-service bit.
- R7: A command with bits[7:5] = 011 clears only in-service bit bits[2:0] (0x60|n clears level n).
- R8: With bit 1 of the mode byte set, an acknowledge sets no in-service bit.
- R9: A command with bit 4 = 0, bit 3 = 1 and bit 1 = 1 selects the address-0 read source: bit 0 = 1 selects in-service (0x0B), bit 0 = 0 selects request (0x0A). Starting configuration selects request. Address-1 reads return the mask.
- R10: An acknowledge with no eligible request returns vec_out = {base[7:3], 3'b111}, even when input 7 is masked, and changes no in-service bit.
- R11: When role_master is high and the winner is an input whose cascade-byte bit is set, the acknowledge drives cas_vld_out high with cas_out equal to that index in the ack cycle. It also sets that in-service bit, and no vector follows (vec_vld stays low).
- R12: With role_master low, the controller answers an acknowledge only when cas_vld_in is high and cas_in equals bits[2:0] of its cascade byte. Otherwise it returns no vector and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| role_master | input | 1 | 1: master, 0: subordinate in a cascade |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0: command port, 1: data/mask port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Readback byte for the current addr |
| irq_in | input | 8 | Interrupt request lines, edge sensed |
| int_out | output | 1 | Interrupt to the processor or to the master |
| ack | input | 1 | Acknowledge strobe |
| cas_out | output | 3 | Cascade identity driven by the master during ack |
| cas_vld_out | output | 1 | Master selected a cascaded input during ack |
| cas_in | input | 3 | Cascade identity seen by a subordinate |
| cas_vld_in | input | 1 | Cascade identity valid |
| vec_out | output | 8 | Interrupt vector |
| vec_vld | output | 1 | vec_out valid, one cycle after a serviced ack |

## Verification
The bench builds a master and a subordinate and configures each one with the full byte sequence. It then goes after nested service, where a lower-priority request must wait behind an in-service level and a higher one must break through. A controller that ignores in-service gating would raise int_out while level 1 is still in service. The spurious case drops a request line before the acknowledge with input 7 masked: a design that trusts the latched request would return the wrong vector and mark a level in service. The cascade case checks that the master stays silent while the subordinate answers, and that the two specific end-of-service commands retire each level on its own chip. The final case uses the shortened sequence, no cascade byte and auto end-of-service, which catches a sequencer that counts the configuration bytes wrongly.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [1:0] {ST_RUN, ST_W2, ST_W3, ST_W4} init_st_e;
   localparam logic [2:0] OP_NSEOI = 3'b001;
   localparam logic [2:0] OP_SEOI  = 3'b011;
endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
   parameter int N  = 8,
   parameter int LW = $clog2(N)
) (
   input  logic [N-1:0]  vec_i,
   output logic          found_o,
   output logic [LW-1:0] idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            found_o = 1'b1;
            idx_o   = LW'(i);
         end
      end
   end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
   import pic_pkg::*;
#(
   parameter int DW   = 8,
   parameter int N_IN = 8,
   parameter int LW   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-LW-1:0] base_q,
   output logic [N_IN-1:0]  icw3_q,
   output logic             aeoi_q,
   output logic [N_IN-1:0]  imr_q,
   output logic             rsel_isr_q,
   output logic             init_clr,
   output logic             eoi_ns,
   output logic             eoi_sp,
   output logic [LW-1:0]    eoi_lvl
);
   init_st_e st_q;
   logic     single_q, need4_q;
   logic     cmd_wr, dat_wr, run_cmd;

   assign cmd_wr   = wr_en & ~addr;
   assign dat_wr   = wr_en & addr;
   assign init_clr = cmd_wr & wdata[4];
   assign run_cmd  = cmd_wr & ~wdata[4] & (st_q == ST_RUN);
   assign eoi_ns   = run_cmd & ~wdata[3] & (wdata[7:5] == OP_NSEOI);
   assign eoi_sp   = run_cmd & ~wdata[3] & (wdata[7:5] == OP_SEOI);
   assign eoi_lvl  = wdata[LW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_RUN;
         single_q   <= 1'b0;
         need4_q    <= 1'b0;
         base_q     <= '0;
         icw3_q     <= '0;
         aeoi_q     <= 1'b0;
         imr_q      <= '1;
         rsel_isr_q <= 1'b0;
      end else if (init_clr) begin
         st_q       <= ST_W2;
         need4_q    <= wdata[0];
         single_q   <= wdata[1];
         icw3_q     <= '0;
         aeoi_q     <= 1'b0;
         imr_q      <= '0;
         rsel_isr_q <= 1'b0;
      end else if (run_cmd && wdata[3] && wdata[1]) begin
         rsel_isr_q <= wdata[0];
      end else if (dat_wr) begin
         unique case (st_q)
            ST_W2: begin
               base_q <= wdata[DW-1:LW];
               st_q   <= single_q ? (need4_q ? ST_W4 : ST_RUN) : ST_W3;
            end
            ST_W3: begin
               icw3_q <= wdata[N_IN-1:0];
               st_q   <= need4_q ? ST_W4 : ST_RUN;
            end
            ST_W4: begin
               aeoi_q <= wdata[1];
               st_q   <= ST_RUN;
            end
            default: imr_q <= wdata[N_IN-1:0];
         endcase
      end
   end

   AST_INIT_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      init_clr |=> (imr_q == '0 && !rsel_isr_q)); // R2
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
   import pic_pkg::*;
#(
   parameter int N_IN    = 8,
   parameter int DW      = 8,
   parameter int IN_SYNC = 0,
   localparam int LW     = $clog2(N_IN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          role_master,
   input  logic          wr_en,
   input  logic          addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [N_IN-1:0] irq_in,
   output logic          int_out,
   input  logic          ack,
   output logic [LW-1:0] cas_out,
   output logic          cas_vld_out,
   input  logic [LW-1:0] cas_in,
   input  logic          cas_vld_in,
   output logic [DW-1:0] vec_out,
   output logic          vec_vld
);
   if (N_IN != (1 << LW)) begin : g_chk_pow2
      $error("N_IN must be a power of two");
   end
   if (N_IN > DW || LW >= DW) begin : g_chk_width
      $error("N_IN must fit in the data width");
   end

   logic [N_IN-1:0] req_s, prev_q, irr_q, isr_q, live;
   logic [N_IN-1:0] irr_clr, isr_set, isr_clr;
   logic [DW-LW-1:0] base_q;
   logic [N_IN-1:0] icw3_q, imr_q;
   logic aeoi_q, rsel_isr_q, init_clr, eoi_ns, eoi_sp;
   logic [LW-1:0] eoi_lvl, lv_idx, is_idx;
   logic lv_found, is_found, eligible, responding, cascaded;
   logic int_q, vld_q;
   logic [DW-1:0] vec_q;

   if (IN_SYNC == 0) begin : g_nosync
      assign req_s = irq_in;
   end else begin : g_sync
      logic [N_IN-1:0] stage_q [IN_SYNC];
      for (genvar s = 0; s < IN_SYNC; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= irq_in;
            else             stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
         end
      end
      assign req_s = stage_q[IN_SYNC-1];
   end

   pic_init_seq #(.DW(DW), .N_IN(N_IN), .LW(LW)) u_seq (
      .clk, .rst_n, .wr_en, .addr, .wdata,
      .base_q, .icw3_q, .aeoi_q, .imr_q, .rsel_isr_q,
      .init_clr, .eoi_ns, .eoi_sp, .eoi_lvl
   );

   assign live = irr_q & req_s & ~imr_q;

   pic_prio_find #(.N(N_IN), .LW(LW)) u_req_find (
      .vec_i(live), .found_o(lv_found), .idx_o(lv_idx));
   pic_prio_find #(.N(N_IN), .LW(LW)) u_isr_find (
      .vec_i(isr_q), .found_o(is_found), .idx_o(is_idx));

   assign eligible   = lv_found && (!is_found || (lv_idx < is_idx));
   assign responding = ack && (role_master || (cas_vld_in && cas_in == icw3_q[LW-1:0]));
   assign cascaded   = role_master && eligible && icw3_q[lv_idx];
   assign cas_out     = lv_idx;
   assign cas_vld_out = ack && cascaded;

   always_comb begin
      irr_clr = '0;
      isr_set = '0;
      isr_clr = '0;
      if (responding && eligible) begin
         irr_clr = N_IN'(1) << lv_idx;
         if (!aeoi_q) isr_set = N_IN'(1) << lv_idx;
      end
      if (eoi_ns && is_found) isr_clr = N_IN'(1) << is_idx;
      if (eoi_sp)             isr_clr = N_IN'(1) << eoi_lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         irr_q  <= '0;
         isr_q  <= '0;
         int_q  <= 1'b0;
         vld_q  <= 1'b0;
         vec_q  <= '0;
      end else begin
         prev_q <= req_s;
         int_q  <= eligible;
         vld_q  <= responding && !cascaded;
         if (responding)
            vec_q <= eligible ? {base_q, lv_idx} : {base_q, {LW{1'b1}}};
         if (init_clr) begin
            irr_q <= '0;
            isr_q <= '0;
         end else begin
            irr_q <= (irr_q & ~irr_clr) | (req_s & ~prev_q);
            isr_q <= (isr_q & ~isr_clr) | isr_set;
         end
      end
   end

   assign int_out = int_q;
   assign vec_vld = vld_q;
   assign vec_out = vec_q;
   assign rdata   = addr ? DW'(imr_q) : DW'(rsel_isr_q ? isr_q : irr_q);

   AST_VLD_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      vec_vld |-> $past(ack)); // R4
   AST_ISR_ONE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(isr_q & ~$past(isr_q)) <= 1); // R5
   AST_NSEOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_ns && is_found) |=> !isr_q[$past(is_idx)]); // R6
   AST_AEOI_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (aeoi_q && !init_clr) |=> ((isr_q & ~$past(isr_q)) == '0)); // R8
   AST_SPUR_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !lv_found && !init_clr) |=> ((isr_q & ~$past(isr_q)) == '0)); // R10
   AST_CAS_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      cas_vld_out |=> !vec_vld); // R11
   AST_SLV_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (!role_master && ack && !wr_en && !(cas_vld_in && cas_in == icw3_q[LW-1:0]))
         |=> (!vec_vld && isr_q == $past(isr_q))); // R12
endmodule

// File: tb/tb_cascade_pic.sv
`timescale 1ns/100ps
module tb_cascade_pic;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       m_wr = 0, s_wr = 0, m_addr = 0, s_addr = 0, ack = 0;
   logic [7:0] m_wdata = 0, s_wdata = 0, m_rdata, s_rdata;
   logic [7:0] irq_m = 0, irq_s = 0;
   logic       m_int, s_int, m_cas_vld, s_cas_vld, m_vld, s_vld;
   logic [2:0] m_cas, s_cas;
   logic [7:0] m_vec, s_vec;
   int n_chk = 0, n_err = 0;

   cascade_pic dut (
      .clk, .rst_n, .role_master(1'b1), .wr_en(m_wr), .addr(m_addr), .wdata(m_wdata),
      .rdata(m_rdata), .irq_in({irq_m[7:3], s_int, irq_m[1:0]}), .int_out(m_int),
      .ack, .cas_out(m_cas), .cas_vld_out(m_cas_vld), .cas_in(3'd0), .cas_vld_in(1'b0),
      .vec_out(m_vec), .vec_vld(m_vld));

   cascade_pic dut_slv (
      .clk, .rst_n, .role_master(1'b0), .wr_en(s_wr), .addr(s_addr), .wdata(s_wdata),
      .rdata(s_rdata), .irq_in(irq_s), .int_out(s_int),
      .ack, .cas_out(s_cas), .cas_vld_out(s_cas_vld), .cas_in(m_cas), .cas_vld_in(m_cas_vld),
      .vec_out(s_vec), .vec_vld(s_vld));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr(input bit slv, input bit a, input logic [7:0] d);
      @(negedge clk);
      if (slv) begin s_wr = 1; s_addr = a; s_wdata = d; end
      else     begin m_wr = 1; m_addr = a; m_wdata = d; end
      @(negedge clk);
      s_wr = 0; m_wr = 0;
   endtask

   task automatic bus_rd(input bit slv, input bit a, output logic [7:0] v);
      @(negedge clk);
      if (slv) s_addr = a; else m_addr = a;
      #1 v = slv ? s_rdata : m_rdata;
   endtask

   task automatic do_ack(output logic cv, output logic [2:0] co, output logic mv,
                         output logic [7:0] mvec, output logic sv, output logic [7:0] svec);
      @(negedge clk);
      ack = 1;
      #1 cv = m_cas_vld; co = m_cas;
      @(negedge clk);
      mv = m_vld; mvec = m_vec; sv = s_vld; svec = s_vec;
      ack = 0;
   endtask

   logic [7:0] rv, mvec, svec;
   logic cv, mv, sv;
   logic [2:0] co;

   task automatic t_reset;
      chk("R1 int_out", m_int, 0);
      chk("R1 vec_vld", m_vld, 0);
      bus_rd(0, 1, rv); chk("R1 mask", rv, 8'hFF);
      bus_rd(0, 0, rv); chk("R1 request", rv, 8'h00);
   endtask

   task automatic t_init;
      bus_wr(0, 0, 8'h11); bus_wr(0, 1, 8'h20); bus_wr(0, 1, 8'h04); bus_wr(0, 1, 8'h01);
      bus_wr(1, 0, 8'h11); bus_wr(1, 1, 8'h28); bus_wr(1, 1, 8'h02); bus_wr(1, 1, 8'h01);
      bus_rd(0, 1, rv); chk("R2 mask cleared", rv, 8'h00);
      bus_wr(0, 1, 8'h5A);
      bus_rd(0, 1, rv); chk("R2 mask write", rv, 8'h5A);
      bus_wr(0, 1, 8'h00);
   endtask

   task automatic t_prio;
      @(negedge clk); irq_m[3] = 1; irq_m[1] = 1;
      settle(3);
      chk("R3 int raised", m_int, 1);
      bus_rd(0, 0, rv); chk("R9 request read", rv, 8'h0A);
      do_ack(cv, co, mv, mvec, sv, svec);
      chk("R4 vld", mv, 1);
      chk("R4 vector", mvec, 8'h21);
      bus_wr(0, 0, 8'h0B);
      bus_rd(0, 0, rv); chk("R5 R9 in-service", rv, 8'h02);
      bus_wr(0, 0, 8'h0A);
      bus_rd(0, 0, rv); chk("R5 request cleared", rv, 8'h08);
      settle(2);
      chk("R3 blocked by in-service", m_int, 0);
      bus_wr(0, 0, 8'h20);
      bus_wr(0, 0, 8'h0B);
      bus_rd(0, 0, rv); chk("R6 nonspecific", rv, 8'h00);
      settle(2);
      chk("R3 int after eoi", m_int, 1);
      do_ack(cv, co, mv, mvec, sv, svec);
      chk("R4 second vector", mvec, 8'h23);
      @(negedge clk); irq_m[0] = 1;
      settle(3);
      chk("R3 nested int", m_int, 1);
      do_ack(cv, co, mv, mvec, sv, svec);
      chk("R4 nested vector", mvec, 8'h20);
      bus_rd(0, 0, rv); chk("R5 nested in-service", rv, 8'h09);
      bus_wr(0, 0, 8'h63);
      bus_rd(0, 0, rv); chk("R7 specific", rv, 8'h01);
      bus_wr(0, 0, 8'h60);
      bus_rd(0, 0, rv); chk("R7 specific level0", rv, 8'h00);
      @(negedge clk); irq_m = 0;
      settle(2);
   endtask

   task automatic t_mask;
      bus_wr(0, 1, 8'h10);
      @(negedge clk); irq_m[4] = 1;
      settle(3);
      chk("R3 masked no int", m_int, 0);
      bus_wr(0, 0, 8'h0A);
      bus_rd(0, 0, rv); chk("R3 masked latched", rv, 8'h10);
      bus_wr(0, 1, 8'h00);
      settle(2);
      chk("R3 unmasked int", m_int, 1);
      do_ack(cv, co, mv, mvec, sv, svec);
      chk("R4 vector 4", mvec, 8'h24);
      bus_wr(0, 0, 8'h20);
      @(negedge clk); irq_m = 0;
      settle(2);
   endtask

   task automatic t_spurious;
      bus_wr(0, 1, 8'h80);
      @(negedge clk); irq_m[6] = 1;
      settle(3);
      @(negedge clk); irq_m[6] = 0;
      settle(2);
      chk("R10 int drops", m_int, 0);
      do_ack(cv, co, mv, mvec, sv, svec);
      chk("R10 vld", mv, 1);
      chk("R10 vector 7", mvec, 8'h27);
      bus_wr(0, 0, 8'h0B);
      bus_rd(0, 0, rv); chk("R10 no in-service", rv, 8'h00);
      bus_wr(0, 1, 8'h00);
   endtask

   task automatic t_cascade;
      @(negedge clk); irq_s[5] = 1;
      settle(5);
      chk("R11 master int via cascade", m_int, 1);
      do_ack(cv, co, mv, mvec, sv, svec);
      chk("R11 cas valid", cv, 1);
      chk("R11 cas id", co, 3'd2);
      chk("R11 master silent", mv, 0);
      chk("R12 slave vld", sv, 1);
      chk("R12 slave vector", svec, 8'h2D);
      bus_rd(0, 0, rv); chk("R11 master in-service", rv, 8'h04);
      bus_wr(1, 0, 8'h0B);
      bus_rd(1, 0, rv); chk("R12 slave in-service", rv, 8'h20);
      bus_wr(1, 0, 8'h65);
      bus_rd(1, 0, rv); chk("R7 slave eoi", rv, 8'h00);
      bus_wr(0, 0, 8'h62);
      bus_rd(0, 0, rv); chk("R7 master cascade eoi", rv, 8'h00);
      @(negedge clk); irq_s = 0; irq_m[1] = 1;
      settle(3);
      do_ack(cv, co, mv, mvec, sv, svec);
      chk("R12 slave not addressed", sv, 0);
      chk("R11 no cas for direct input", cv, 0);
      chk("R4 master direct vector", mvec, 8'h21);
      bus_rd(1, 0, rv); chk("R12 slave state unchanged", rv, 8'h00);
      bus_wr(0, 0, 8'h20);
      @(negedge clk); irq_m = 0;
      settle(2);
   endtask

   task automatic t_single_aeoi;
      bus_wr(0, 0, 8'h13); bus_wr(0, 1, 8'h40); bus_wr(0, 1, 8'h02);
      bus_wr(0, 1, 8'h3C);
      bus_rd(0, 1, rv); chk("R2 cascade byte skipped", rv, 8'h3C);
      bus_wr(0, 1, 8'h00);
      @(negedge clk); irq_m[5] = 1;
      settle(3);
      do_ack(cv, co, mv, mvec, sv, svec);
      chk("R4 new base vector", mvec, 8'h45);
      bus_rd(0, 0, rv); chk("R5 request cleared aeoi", rv, 8'h00);
      bus_wr(0, 0, 8'h0B);
      bus_rd(0, 0, rv); chk("R8 auto eoi", rv, 8'h00);
      @(negedge clk); irq_m = 0;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      settle(4);
      rst_n = 1;
      settle(1);
      t_reset();
      t_init();
      t_prio();
      t_mask();
      t_spurious();
      t_cascade();
      t_single_aeoi();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule